// File: doc/BRIEF.md
# VMID-Tagged Translation Buffer

This block caches finished guest translations for a processor that hosts several virtual machines. Each of its entries maps one guest virtual page or block straight to a final physical page or block. Each entry carries the identifier of the virtual machine that owns it, so the translations of many guests sit side by side and never alias. A lookup presents a guest virtual address together with the identifier of the running guest. The answer comes back in the same cycle, and a registered copy follows one cycle later.

A walker outside the block installs entries through a fill port. Each entry carries one of six mapping granularities: three base page sizes and three large block sizes. A hypervisor uses the invalidate port before it gives an identifier to a new guest. That port clears either one guest's entries or the whole buffer. The buffer has sixteen entries by default. Once it is full, a round-robin pointer picks the entry to replace.

Top module: `vmid_tlb`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and `lk_hit_q` and `lk_pa_q` are 0.
- R2: A lookup hits only when an entry is valid, its stored VMID equals `lk_vmid` in every bit, and its virtual tag equals the address bits above the entry's page offset.
- R3: The size code selects the offset width: 0 = 4 KiB (12 bits), 1 = 16 KiB (14), 2 = 64 KiB (16), 3 = 2 MiB (21), 4 = 32 MiB (25), 5 = 512 MiB (29). Codes 6 and 7 act as 4 KiB. On a hit, `lk_pa` holds the stored physical bits above the offset and the lookup address bits below it. On a miss, `lk_pa` is 0.
- R4: `lk_hit_q` and `lk_pa_q` equal the `lk_hit` and `lk_pa` values of the previous cycle.
- R5: A fill writes to one slot, chosen as follows. First choice is the valid entry with the same VMID, size code and tag, which is overwritten in place. Otherwise the fill takes the lowest-index invalid entry. If no entry is invalid, the fill takes the entry under the replacement pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on that last kind of fill.
- R6: When several entries match one lookup, the entry with the lowest index supplies the result.
- R7: An invalidate by VMID clears every entry with that VMID on the next edge. Entries of other VMIDs keep hitting.
- R8: An invalidate-all clears every entry in one cycle.
- R9: In a cycle where either invalidate is asserted, a lookup reports a miss and a fill is dropped.
- R10: The VMID width is a parameter, 8 bits by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Guest virtual address to translate |
| lk_vmid | input | VMID_W | VMID of the running guest |
| lk_hit | output | 1 | Same-cycle hit |
| lk_pa | output | PA_W | Same-cycle physical address, 0 on miss |
| lk_hit_q | output | 1 | Hit registered one cycle later |
| lk_pa_q | output | PA_W | Physical address registered one cycle later |
| fl_en | input | 1 | Install an entry |
| fl_va | input | VA_W | Virtual address of the new mapping |
| fl_pa | input | PA_W | Physical address of the new mapping |
| fl_vmid | input | VMID_W | VMID owning the new mapping |
| fl_size | input | 3 | Size code of the new mapping |
| inv_vmid_en | input | 1 | Invalidate the entries of one VMID |
| inv_vmid | input | VMID_W | VMID to invalidate |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The bench installs a mapping of every size code. For each one it checks the lowest offset, the highest offset, a bit pattern inside the offset, and the first address past the mapping. A design with a wrong mask would merge address bits at the wrong position, or would hit just outside the region. The bench fills all sixteen slots and then forces replacements and a refill of a mapping that is already present. A design that took a new slot for the duplicate, or that moved the pointer on it, would evict a neighbour that the bench expects to find. Overlapping large and small mappings are placed in both orders to expose the wrong priority. Invalidate commands are raised in the same cycle as a lookup and as a fill, and by VMID with other guests present. A design that let either through, or that cleared too much, would show a hit or a loss that the bench does not expect.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

  localparam int unsigned BASE_SHIFT = 12;
  localparam int unsigned OFF_MAX    = 29;

  typedef enum logic [2:0] {
    SZ_4K   = 3'd0,
    SZ_16K  = 3'd1,
    SZ_64K  = 3'd2,
    SZ_2M   = 3'd3,
    SZ_32M  = 3'd4,
    SZ_512M = 3'd5
  } map_size_e;

  // Offset width in bits for a size code; unknown codes behave as 4 KiB.
  function automatic int unsigned off_bits(input logic [2:0] code);
    case (map_size_e'(code))
      SZ_16K:  return 14;
      SZ_64K:  return 16;
      SZ_2M:   return 21;
      SZ_32M:  return 25;
      SZ_512M: return 29;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/vtlb_tag_cmp.sv
module vtlb_tag_cmp
  import vtlb_pkg::*;
#(
  parameter int unsigned VPN_W  = 36,
  parameter int unsigned VMID_W = 8
) (
  input  logic              ent_valid,
  input  logic [VMID_W-1:0] ent_vmid,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [2:0]        ent_size,
  input  logic [VMID_W-1:0] q_vmid,
  input  logic [VPN_W-1:0]  q_vpn,
  output logic              match
);

  logic [VPN_W-1:0] keep;

  always_comb begin
    keep  = ~((VPN_W'(1) << (off_bits(ent_size) - BASE_SHIFT)) - VPN_W'(1));
    match = ent_valid && (ent_vmid == q_vmid) &&
            (((ent_vpn ^ q_vpn) & keep) == '0);
  end

endmodule

// File: rtl/vtlb_pick_first.sv
module vtlb_pick_first #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (found && !$isunknown(req)) begin
      AST_PICK_LOWEST: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)); // R6
    end
  end

endmodule

// File: rtl/vmid_tlb.sv
module vmid_tlb
  import vtlb_pkg::*;
#(
  parameter int unsigned N_ENT  = 16,
  parameter int unsigned VA_W   = 48,
  parameter int unsigned PA_W   = 44,
  parameter int unsigned VMID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [VMID_W-1:0] lk_vmid,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_pa,
  output logic              lk_hit_q,
  output logic [PA_W-1:0]   lk_pa_q,
  input  logic              fl_en,
  input  logic [VA_W-1:0]   fl_va,
  input  logic [PA_W-1:0]   fl_pa,
  input  logic [VMID_W-1:0] fl_vmid,
  input  logic [2:0]        fl_size,
  input  logic              inv_vmid_en,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic              inv_all
);

  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int unsigned VPN_W = VA_W - BASE_SHIFT;
  localparam int unsigned PPN_W = PA_W - BASE_SHIFT;

  // entry state
  logic [N_ENT-1:0]  vld, vld_nxt;
  logic [VMID_W-1:0] tag_vmid [N_ENT];
  logic [VPN_W-1:0]  tag_vpn  [N_ENT];
  logic [PPN_W-1:0]  map_ppn  [N_ENT];
  logic [2:0]        map_size [N_ENT];
  logic [IDX_W-1:0]  rr_ptr, rr_nxt;

  // lookup and fill decode
  logic [N_ENT-1:0] lk_match, dup_match, wr_en;
  logic             lk_any, dup_any, free_any;
  logic [IDX_W-1:0] lk_idx, dup_idx, free_idx, fill_idx;
  logic             inv_any, fill_go;
  logic [PPN_W-1:0] sel_ppn;
  logic [2:0]       sel_size;
  logic [PA_W-1:0]  off_mask;

  assign inv_any = inv_vmid_en | inv_all;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic dup_tag;

    vtlb_tag_cmp #(.VPN_W(VPN_W), .VMID_W(VMID_W)) u_lk_cmp (
      .ent_valid (vld[g]),
      .ent_vmid  (tag_vmid[g]),
      .ent_vpn   (tag_vpn[g]),
      .ent_size  (map_size[g]),
      .q_vmid    (lk_vmid),
      .q_vpn     (lk_va[VA_W-1:BASE_SHIFT]),
      .match     (lk_match[g])
    );

    vtlb_tag_cmp #(.VPN_W(VPN_W), .VMID_W(VMID_W)) u_dup_cmp (
      .ent_valid (vld[g]),
      .ent_vmid  (tag_vmid[g]),
      .ent_vpn   (tag_vpn[g]),
      .ent_size  (map_size[g]),
      .q_vmid    (fl_vmid),
      .q_vpn     (fl_va[VA_W-1:BASE_SHIFT]),
      .match     (dup_tag)
    );

    assign dup_match[g] = dup_tag && (map_size[g] == fl_size);

    AST_VMID_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
      inv_vmid_en |=> !(vld[g] && (tag_vmid[g] == $past(inv_vmid)))); // R7
  end

  vtlb_pick_first #(.N(N_ENT), .IDX_W(IDX_W)) u_pick_hit (
    .req (lk_match), .found (lk_any), .idx (lk_idx)
  );

  vtlb_pick_first #(.N(N_ENT), .IDX_W(IDX_W)) u_pick_dup (
    .req (dup_match), .found (dup_any), .idx (dup_idx)
  );

  vtlb_pick_first #(.N(N_ENT), .IDX_W(IDX_W)) u_pick_free (
    .req (~vld), .found (free_any), .idx (free_idx)
  );

  // combinational lookup result
  always_comb begin
    sel_ppn  = map_ppn[lk_idx];
    sel_size = map_size[lk_idx];
    off_mask = (PA_W'(1) << off_bits(sel_size)) - PA_W'(1);
    lk_hit   = lk_valid && !inv_any && lk_any;
    lk_pa    = lk_hit ? (({sel_ppn, {BASE_SHIFT{1'b0}}} & ~off_mask) |
                         (PA_W'(lk_va[OFF_MAX-1:0]) & off_mask))
                      : '0;
  end

  // next state
  always_comb begin
    fill_go  = fl_en && !inv_any;
    fill_idx = dup_any ? dup_idx : (free_any ? free_idx : rr_ptr);
    rr_nxt   = rr_ptr;
    if (fill_go && !dup_any && !free_any) begin
      rr_nxt = (rr_ptr == IDX_W'(N_ENT - 1)) ? '0 : rr_ptr + IDX_W'(1);
    end
    for (int i = 0; i < N_ENT; i++) begin
      wr_en[i]   = fill_go && (fill_idx == IDX_W'(i));
      vld_nxt[i] = vld[i];
      if (inv_all) begin
        vld_nxt[i] = 1'b0;
      end else if (inv_vmid_en && (tag_vmid[i] == inv_vmid)) begin
        vld_nxt[i] = 1'b0;
      end else if (wr_en[i]) begin
        vld_nxt[i] = 1'b1;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld      <= '0;
      rr_ptr   <= '0;
      lk_hit_q <= 1'b0;
      lk_pa_q  <= '0;
    end else begin
      vld      <= vld_nxt;
      rr_ptr   <= rr_nxt;
      lk_hit_q <= lk_hit;
      lk_pa_q  <= lk_pa;
    end
  end

  // entry payload, write-enabled, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < N_ENT; i++) begin
      if (wr_en[i]) begin
        tag_vmid[i] <= fl_vmid;
        tag_vpn[i]  <= fl_va[VA_W-1:BASE_SHIFT];
        map_ppn[i]  <= fl_pa[PA_W-1:BASE_SHIFT];
        map_size[i] <= fl_size;
      end
    end
  end

  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld == '0)); // R8

  AST_NO_HIT_UNDER_INV: assert property (@(posedge clk) disable iff (!rst_n)
    inv_any |=> !lk_hit_q); // R9

  AST_PTR_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rr_ptr) |-> (($past(rr_ptr) == IDX_W'(N_ENT - 1)) ?
                          (rr_ptr == '0) : (rr_ptr == $past(rr_ptr) + IDX_W'(1)))); // R5

  AST_PTR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rr_ptr) |-> ($past(vld) == '1)); // R5

endmodule

// File: tb/test_vmid_tlb.sv
module test_vmid_tlb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [47:0] lk_va;
  logic [7:0]  lk_vmid;
  logic        lk_hit;
  logic [43:0] lk_pa;
  logic        lk_hit_q;
  logic [43:0] lk_pa_q;
  logic        fl_en;
  logic [47:0] fl_va;
  logic [43:0] fl_pa;
  logic [7:0]  fl_vmid;
  logic [2:0]  fl_size;
  logic        inv_vmid_en;
  logic [7:0]  inv_vmid;
  logic        inv_all;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vmid_tlb i_vmid_tlb (
    .clk (clk), .rst_n (rst_n),
    .lk_valid (lk_valid), .lk_va (lk_va), .lk_vmid (lk_vmid),
    .lk_hit (lk_hit), .lk_pa (lk_pa), .lk_hit_q (lk_hit_q), .lk_pa_q (lk_pa_q),
    .fl_en (fl_en), .fl_va (fl_va), .fl_pa (fl_pa), .fl_vmid (fl_vmid), .fl_size (fl_size),
    .inv_vmid_en (inv_vmid_en), .inv_vmid (inv_vmid), .inv_all (inv_all)
  );

  function automatic logic [43:0] epa(input logic [43:0] pa, input logic [47:0] va, input int sz);
    int          ob;
    logic [43:0] m;
    case (sz)
      1: ob = 14;
      2: ob = 16;
      3: ob = 21;
      4: ob = 25;
      5: ob = 29;
      default: ob = 12;
    endcase
    m = (44'd1 << ob) - 44'd1;
    return (pa & ~m) | (va[43:0] & m);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [47:0] va, input logic [7:0] vm, input logic eh,
                      input logic [43:0] ep, input string tag);
    lk_valid = 1'b1; lk_va = va; lk_vmid = vm;
    #1;
    chk({tag, " hit"}, 64'(lk_hit), 64'(eh));
    chk({tag, " pa"},  64'(lk_pa),  eh ? 64'(ep) : 64'd0);
    @(negedge clk);
    chk({tag, " R4 hit_q"}, 64'(lk_hit_q), 64'(eh));
    chk({tag, " R4 pa_q"},  64'(lk_pa_q),  eh ? 64'(ep) : 64'd0);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [47:0] va, input logic [43:0] pa, input logic [7:0] vm,
                      input logic [2:0] sz);
    fl_en = 1'b1; fl_va = va; fl_pa = pa; fl_vmid = vm; fl_size = sz;
    @(negedge clk);
    fl_en = 1'b0;
  endtask

  task automatic flush_all();
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
  endtask

  task automatic flush_vm(input logic [7:0] vm);
    inv_vmid_en = 1'b1; inv_vmid = vm;
    @(negedge clk);
    inv_vmid_en = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] va, vb, px [4];
    logic [43:0] pa;
    rst_n = 1'b0; lk_valid = 1'b0; lk_va = '0; lk_vmid = '0;
    fl_en = 1'b0; fl_va = '0; fl_pa = '0; fl_vmid = '0; fl_size = '0;
    inv_vmid_en = 1'b0; inv_vmid = '0; inv_all = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 hit_q after reset", 64'(lk_hit_q), 64'd0);
    chk("R1 pa_q after reset",  64'(lk_pa_q),  64'd0);
    look(48'h0, 8'h00, 1'b0, 44'h0, "R1 empty lookup");
    look(48'h1234_5678_9000, 8'h7F, 1'b0, 44'h0, "R1 empty lookup");

    // R3 / R2 sweep over every size code
    for (int s = 0; s < 6; s++) begin
      int ob;
      logic [47:0] base, span;
      ob   = (s == 0) ? 12 : (s == 1) ? 14 : (s == 2) ? 16 : (s == 3) ? 21 : (s == 4) ? 25 : 29;
      span = 48'd1 << ob;
      base = 48'h0123_6000_0000;
      pa   = 44'h987_6543_2100;
      flush_all();
      fill(base, pa, 8'h11, 3'(s));
      look(base, 8'h11, 1'b1, epa(pa, base, s), "R3 low offset");
      look(base + span - 48'd1, 8'h11, 1'b1, epa(pa, base + span - 48'd1, s), "R3 top offset");
      va = base | (48'h5555_5555 & (span - 48'd1));
      look(va, 8'h11, 1'b1, epa(pa, va, s), "R3 offset pattern");
      look(base + span, 8'h11, 1'b0, 44'h0, "R2 past region");
      look(base, 8'h91, 1'b0, 44'h0, "R10 VMID top bit");
      look(base, 8'h10, 1'b0, 44'h0, "R2 VMID low bit");
    end

    // R5 fill all slots, then replacement by pointer
    flush_all();
    for (int i = 0; i < 16; i++)
      fill(48'h700_0000 + 48'(i) * 48'h1000, 44'h55_0000_0000 + 44'(i) * 44'h1000, 8'(8'h20 + i), 3'd0);
    for (int i = 0; i < 16; i++) begin
      va = 48'h700_0000 + 48'(i) * 48'h1000;
      look(va, 8'(8'h20 + i), 1'b1, epa(44'h55_0000_0000 + 44'(i) * 44'h1000, va, 0), "R5 full table");
    end
    fill(48'h900_0000, 44'h66_0000_0000, 8'h40, 3'd0);
    look(48'h700_0000, 8'h20, 1'b0, 44'h0, "R5 slot 0 replaced");
    look(48'h900_0abc, 8'h40, 1'b1, epa(44'h66_0000_0000, 48'h900_0abc, 0), "R5 new entry");
    look(48'h700_1000, 8'h21, 1'b1, epa(44'h55_0000_1000, 48'h700_1000, 0), "R5 slot 1 kept");
    // duplicate refill overwrites in place, pointer unaffected
    fill(48'h700_5000, 44'h77_7777_7000, 8'h25, 3'd0);
    look(48'h700_5010, 8'h25, 1'b1, epa(44'h77_7777_7000, 48'h700_5010, 0), "R5 duplicate new pa");
    look(48'h700_1000, 8'h21, 1'b1, epa(44'h55_0000_1000, 48'h700_1000, 0), "R5 duplicate no eviction");
    fill(48'h901_0000, 44'h68_0000_0000, 8'h41, 3'd0);
    look(48'h700_1000, 8'h21, 1'b0, 44'h0, "R5 slot 1 replaced");
    look(48'h700_2000, 8'h22, 1'b1, epa(44'h55_0000_2000, 48'h700_2000, 0), "R5 slot 2 kept");

    // R6 overlapping mappings, both orders
    va = 48'h4000_1234;
    flush_all();
    fill(48'h4000_0000, 44'h111_0000_0000, 8'h01, 3'd3);
    fill(48'h4000_1000, 44'h222_2222_2000, 8'h01, 3'd0);
    look(va, 8'h01, 1'b1, epa(44'h111_0000_0000, va, 3), "R6 block in slot 0");
    flush_all();
    fill(48'h4000_1000, 44'h222_2222_2000, 8'h01, 3'd0);
    fill(48'h4000_0000, 44'h111_0000_0000, 8'h01, 3'd3);
    look(va, 8'h01, 1'b1, epa(44'h222_2222_2000, va, 0), "R6 page in slot 0");

    // R7 invalidate by VMID
    flush_all();
    px[0] = 48'h8000_0000; px[1] = 48'h8000_1000; px[2] = 48'h8000_2000; px[3] = 48'h8000_3000;
    fill(px[0], 44'h300_0000_0000, 8'h01, 3'd0);
    fill(px[1], 44'h301_0000_1000, 8'h02, 3'd0);
    fill(px[2], 44'h302_0000_2000, 8'h01, 3'd0);
    fill(px[3], 44'h303_0000_3000, 8'h03, 3'd0);
    flush_vm(8'h01);
    look(px[0], 8'h01, 1'b0, 44'h0, "R7 flushed vmid slot 0");
    look(px[2], 8'h01, 1'b0, 44'h0, "R7 flushed vmid slot 2");
    look(px[1], 8'h02, 1'b1, epa(44'h301_0000_1000, px[1], 0), "R7 other vmid kept");
    look(px[3], 8'h03, 1'b1, epa(44'h303_0000_3000, px[3], 0), "R7 other vmid kept");
    // R5 lowest free slot (0) used: block over px[1] now wins over slot 1
    fill(48'h8000_0000, 44'h3AA_0000_0000, 8'h02, 3'd3);
    look(px[1], 8'h02, 1'b1, epa(44'h3AA_0000_0000, px[1], 3), "R5 lowest free slot");

    // R9 lookup and fill under an invalidate
    vb = px[1] + 48'h44;
    lk_valid = 1'b1; lk_va = vb; lk_vmid = 8'h02;
    inv_vmid_en = 1'b1; inv_vmid = 8'h09;
    #1;
    chk("R9 hit under invalidate", 64'(lk_hit), 64'd0);
    @(negedge clk);
    inv_vmid_en = 1'b0; lk_valid = 1'b0;
    chk("R9 hit_q under invalidate", 64'(lk_hit_q), 64'd0);
    look(vb, 8'h02, 1'b1, epa(44'h3AA_0000_0000, vb, 3), "R9 entry survives");
    fl_en = 1'b1; fl_va = 48'hA000_0000; fl_pa = 44'h444_0000_0000; fl_vmid = 8'h09; fl_size = 3'd0;
    inv_vmid_en = 1'b1; inv_vmid = 8'h09;
    @(negedge clk);
    fl_en = 1'b0; inv_vmid_en = 1'b0;
    look(48'hA000_0000, 8'h09, 1'b0, 44'h0, "R9 fill dropped");
    fl_en = 1'b1; fl_va = 48'hB000_0000; fl_pa = 44'h445_0000_0000; fl_vmid = 8'h0A; fl_size = 3'd0;
    inv_all = 1'b1;
    @(negedge clk);
    fl_en = 1'b0; inv_all = 1'b0;
    look(48'hB000_0000, 8'h0A, 1'b0, 44'h0, "R9 fill dropped under flush all");

    // R8 flush all
    fill(px[3], 44'h303_0000_3000, 8'h03, 3'd0);
    look(px[3], 8'h03, 1'b1, epa(44'h303_0000_3000, px[3], 0), "R8 before flush");
    flush_all();
    look(px[3], 8'h03, 1'b0, 44'h0, "R8 after flush");
    look(px[1], 8'h02, 1'b0, 44'h0, "R8 after flush");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule